// File: doc/BRIEF.md
# Sine-cosine half-angle evaluator

This unit takes one signed fixed-point angle and returns its sine and its cosine together. It does not use a rotation-based or table-based method. It squares the angle once. It then runs two Horner polynomial chains side by side: an odd chain that leads to sin(x/2) and an even chain that gives cos(x/2). Double-angle identities turn those two values into sin(x) and cos(x).

All steps share one two-lane multiply-add datapath. A small step counter chooses the operands for each step. A request is a one-cycle `start_i` pulse with the angle. The answer comes back with a one-cycle `done_o` pulse, and both results stay on the outputs until the next answer. The caller must first reduce the angle to the range [-pi, pi].

Top module: `sincos_half_eval`

## Requirements
- R1: While `rst_ni` is low and after its release, `done_o` is 0 and `sin_o` and `cos_o` are 0 until the first result.
- R2: A `start_i` sampled high while the unit is idle captures `angle_i`. `done_o` is then high for exactly one cycle, 7 clock edges after the capturing edge.
- R3: `angle_i` is signed Q3.16 (19 bits, value = integer / 65536). `sin_o` is signed Q1.16 (18 bits). For every angle in [-pi, pi], |sin_o/65536 - sin(angle)| <= 0.002.
- R4: `cos_o` is signed Q1.16 (18 bits). For every angle in [-pi, pi], |cos_o/65536 - cos(angle)| <= 0.002.
- R5: A `start_i` that arrives while an operation is in progress is ignored. The current result and the timing of its `done_o` do not change.
- R6: A `start_i` sampled in the same cycle that `done_o` is high is accepted as a new request.
- R7: `sin_o` and `cos_o` change only at the edge that raises `done_o`. Between results they hold, whatever `start_i` and `angle_i` do while idle.
- R8: An angle of exactly 0 gives `sin_o` = 0 and `cos_o` = 65536 (1.0) exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled while idle |
| angle_i | input | 19 | Angle in radians, signed Q3.16 |
| done_o | output | 1 | One-cycle result strobe |
| sin_o | output | 18 | sin(angle), signed Q1.16 |
| cos_o | output | 18 | cos(angle), signed Q1.16 |

## Verification
Two events can fall in the same cycle: the completion strobe of one operation and the acceptance of the next request. The bench raises `start_i` in exactly the cycle where `done_o` is seen high. It then checks that a second `done_o` follows 7 edges later, with results that match the new angle within the accuracy bound. A request pulse injected in the middle of a busy operation is judged against the first operation's exact earlier outputs and its unchanged latency.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [2:0] {
    STP_SQ   = 3'd0,
    STP_H1   = 3'd1,
    STP_H2   = 3'd2,
    STP_H3   = 3'd3,
    STP_HALF = 3'd4,
    STP_PROD = 3'd5,
    STP_FIN  = 3'd6
  } step_e;

  localparam int NSTEP = 7;

  // rounded 2^wf / den
  function automatic longint recip(input longint den, input int wf);
    return ((longint'(1) <<< wf) + den / 2) / den;
  endfunction
endpackage

// File: rtl/sc_seq.sv
module sc_seq #(
  parameter int NSTEP = 7,
  parameter int SW    = $clog2(NSTEP)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic [SW-1:0] step_o,
  output logic          done_o
);
  logic          busy_q, done_q, last;
  logic [SW-1:0] step_q;

  assign accept_o = start_i && !busy_q;
  assign last     = busy_q && (step_q == SW'(NSTEP - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (accept_o) begin
        busy_q <= 1'b1;
        step_q <= '0;
      end else if (last) begin
        busy_q <= 1'b0;
        step_q <= '0;
      end else if (busy_q) begin
        step_q <= step_q + SW'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign step_o = step_q;
  assign done_o = done_q;

  AST_ACCEPT_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> busy_q && step_q == '0); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R2
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> done_q); // R2
  AST_BUSY_IGNORES_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last) |=> busy_q && step_q == $past(step_q) + SW'(1)); // R5
  AST_IDLE_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q); // R6
endmodule

// File: rtl/sc_opsel.sv
module sc_opsel
  import sc_pkg::*;
#(
  parameter int DW = 32,
  parameter int WF = 24
) (
  input  step_e                step_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] z_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  output logic signed [DW-1:0] m_o [2],
  output logic signed [DW-1:0] k_o [2],
  output logic signed [DW-1:0] c_o [2]
);
  // odd lane: x*(1/2 - z/(3!*8) + z^2/(5!*32) - z^3/(7!*128))
  localparam logic signed [DW-1:0] C_S7 = -DW'(recip(64'd645120, WF));
  localparam logic signed [DW-1:0] C_S5 =  DW'(recip(64'd3840, WF));
  localparam logic signed [DW-1:0] C_S3 = -DW'(recip(64'd48, WF));
  // even lane: 1 - z/(2!*4) + z^2/(4!*16) - z^3/(6!*64)
  localparam logic signed [DW-1:0] C_C6 = -DW'(recip(64'd46080, WF));
  localparam logic signed [DW-1:0] C_C4 =  DW'(recip(64'd384, WF));
  localparam logic signed [DW-1:0] C_C2 = -DW'(recip(64'd8, WF));
  localparam logic signed [DW-1:0] K_HALF = DW'(longint'(1) <<< (WF - 1));
  localparam logic signed [DW-1:0] K_ONE  = DW'(longint'(1) <<< WF);
  localparam logic signed [DW-1:0] K_TWO  = DW'(longint'(2) <<< WF);
  localparam logic signed [DW-1:0] K_NTWO = -K_TWO;

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      m_o[l] = '0;
      k_o[l] = '0;
      c_o[l] = '0;
    end
    unique case (step_i)
      STP_SQ: begin
        m_o[0] = x_i; k_o[0] = x_i;
      end
      STP_H1: begin
        m_o[0] = z_i; k_o[0] = C_S7; c_o[0] = C_S5;
        m_o[1] = z_i; k_o[1] = C_C6; c_o[1] = C_C4;
      end
      STP_H2: begin
        m_o[0] = a_i; k_o[0] = z_i; c_o[0] = C_S3;
        m_o[1] = b_i; k_o[1] = z_i; c_o[1] = C_C2;
      end
      STP_H3: begin
        m_o[0] = a_i; k_o[0] = z_i; c_o[0] = K_HALF;
        m_o[1] = b_i; k_o[1] = z_i; c_o[1] = K_ONE;
      end
      STP_HALF: begin
        m_o[0] = a_i; k_o[0] = x_i;
        m_o[1] = b_i; k_o[1] = K_ONE;
      end
      STP_PROD: begin
        m_o[0] = a_i; k_o[0] = a_i;
        m_o[1] = a_i; k_o[1] = b_i;
      end
      STP_FIN: begin
        m_o[0] = a_i; k_o[0] = K_NTWO; c_o[0] = K_ONE;
        m_o[1] = b_i; k_o[1] = K_TWO;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_mac2.sv
module sc_mac2 #(
  parameter int DW    = 32,
  parameter int WF    = 24,
  parameter int LANES = 2
) (
  input  logic signed [DW-1:0] m_i [LANES],
  input  logic signed [DW-1:0] k_i [LANES],
  input  logic signed [DW-1:0] c_i [LANES],
  output logic signed [DW-1:0] r_o [LANES]
);
  localparam int PW = 2 * DW;
  localparam logic signed [PW-1:0] RND = PW'(1) <<< (WF - 1);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [PW-1:0] prod, rnd;
    logic signed [DW-1:0] scaled;
    assign prod   = m_i[l] * k_i[l];
    assign rnd    = prod + RND;
    assign scaled = DW'(rnd >>> WF);
    assign r_o[l] = scaled + c_i[l];
  end
endmodule

// File: rtl/sincos_half_eval.sv
module sincos_half_eval
  import sc_pkg::*;
#(
  parameter int FRAC_IN = 16,
  parameter int ANGLE_W = 19,
  parameter int OUT_W   = 18,
  parameter int WF      = 24,
  parameter int DW      = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic signed [ANGLE_W-1:0] angle_i,
  output logic                      done_o,
  output logic signed [OUT_W-1:0]   sin_o,
  output logic signed [OUT_W-1:0]   cos_o
);
  localparam int SW     = $clog2(NSTEP);
  localparam int SH_IN  = WF - FRAC_IN;
  localparam logic signed [DW-1:0] OUT_RND = DW'(1) <<< (SH_IN - 1);
  localparam logic signed [OUT_W-1:0] LIM =
    OUT_W'((1 << FRAC_IN) + (1 << FRAC_IN) / 500);

  logic          accept, busy;
  logic [SW-1:0] step_w;
  step_e         step;

  logic signed [DW-1:0] x_q, z_q, a_q, b_q, ang_ext;
  logic signed [DW-1:0] m_w [2];
  logic signed [DW-1:0] k_w [2];
  logic signed [DW-1:0] c_w [2];
  logic signed [DW-1:0] r_w [2];
  logic signed [OUT_W-1:0] sin_q, cos_q;

  sc_seq #(.NSTEP(NSTEP), .SW(SW)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy),
    .step_o   (step_w),
    .done_o   (done_o)
  );

  assign step = step_e'(step_w);

  sc_opsel #(.DW(DW), .WF(WF)) i_opsel (
    .step_i (step),
    .x_i    (x_q),
    .z_i    (z_q),
    .a_i    (a_q),
    .b_i    (b_q),
    .m_o    (m_w),
    .k_o    (k_w),
    .c_o    (c_w)
  );

  sc_mac2 #(.DW(DW), .WF(WF), .LANES(2)) i_mac (
    .m_i (m_w),
    .k_i (k_w),
    .c_i (c_w),
    .r_o (r_w)
  );

  assign ang_ext = DW'(angle_i);

  function automatic logic signed [OUT_W-1:0] to_out(input logic signed [DW-1:0] v);
    return OUT_W'((v + OUT_RND) >>> SH_IN);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q   <= '0;
      z_q   <= '0;
      a_q   <= '0;
      b_q   <= '0;
      sin_q <= '0;
      cos_q <= '0;
    end else if (accept) begin
      x_q <= ang_ext <<< SH_IN;
    end else if (busy) begin
      unique case (step)
        STP_SQ: z_q <= r_w[0];
        STP_H1, STP_H2, STP_H3, STP_PROD: begin
          a_q <= r_w[0];
          b_q <= r_w[1];
        end
        STP_HALF: a_q <= r_w[0];
        STP_FIN: begin
          cos_q <= to_out(r_w[0]);
          sin_q <= to_out(r_w[1]);
        end
        default: ;
      endcase
    end
  end

  assign sin_o = sin_q;
  assign cos_o = cos_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && step == STP_SQ) |=> z_q >= 0); // R3
  AST_SIN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (sin_o <= LIM) && (sin_o >= -LIM)); // R3
  AST_COS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cos_o <= LIM) && (cos_o >= -LIM)); // R4
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(sin_o) && $stable(cos_o)); // R7
endmodule

// File: tb/test_sincos_half_eval.sv
module test_sincos_half_eval;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic signed [18:0] angle_i = '0;
  logic done_o;
  logic signed [17:0] sin_o, cos_o;

  int total = 0, bad = 0, cyc = 0;
  localparam real TOL = 0.002;
  localparam real PI = 3.14159265358979;
  localparam int NTAB = 10;
  localparam int ANG_TAB [NTAB] = '{0, 205887, -205887, 102944, -102944,
                                    51472, 65536, -163840, 1, -1};

  sincos_half_eval i_sincos_half_eval (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .angle_i(angle_i),
    .done_o(done_o), .sin_o(sin_o), .cos_o(cos_o)
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk_int(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_err(input string req, input int ang, input int got, input bit is_sin);
    real a, r, e;
    a = $itor(ang) / 65536.0;
    r = is_sin ? $sin(a) : $cos(a);
    e = $itor(got) / 65536.0 - r;
    if (e < 0.0) e = -e;
    total++;
    if (e > TOL) begin
      bad++;
      $display("FAIL %s angle=%0d: actual=%f expected=%f", req, ang, $itor(got) / 65536.0, r);
    end
  endtask

  task automatic run_op(input int ang, output int s, output int c, output int lat);
    @(negedge clk_i);
    start_i = 1'b1;
    angle_i = ang[18:0];
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 50) begin
      @(negedge clk_i);
      lat++;
    end
    s = sin_o;
    c = cos_o;
  endtask

  initial begin
    int s, c, lat, s_a, c_a;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk_int("R1 done in reset", done_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_int("R1 done after reset", done_o, 0);
    chk_int("R1 sin after reset", sin_o, 0);
    chk_int("R1 cos after reset", cos_o, 0);

    // table of angles: R2 latency, R3 sine, R4 cosine
    for (int i = 0; i < NTAB; i++) begin
      run_op(ANG_TAB[i], s, c, lat);
      chk_int("R2 latency", lat, 7);
      chk_err("R3 sin", ANG_TAB[i], s, 1'b1);
      chk_err("R4 cos", ANG_TAB[i], c, 1'b0);
      if (ANG_TAB[i] == 0) begin
        chk_int("R8 sin at zero", s, 0);
        chk_int("R8 cos at zero", c, 65536);
      end
    end

    // sweep across [-pi, pi]
    for (int i = 0; i <= 200; i++) begin
      int ang;
      ang = -205887 + i * 2058;
      run_op(ang, s, c, lat);
      chk_err("R3 sweep sin", ang, s, 1'b1);
      chk_err("R4 sweep cos", ang, c, 1'b0);
    end

    // R2 done pulse width
    run_op(-140000, s_a, c_a, lat);
    @(negedge clk_i);
    chk_int("R2 done one cycle", done_o, 0);

    // R7 hold while idle with stray angle changes
    for (int i = 0; i < 4; i++) begin
      angle_i = 19'(i * 9999);
      @(negedge clk_i);
    end
    chk_int("R7 sin hold", sin_o, s_a);
    chk_int("R7 cos hold", cos_o, c_a);
    chk_int("R7 no done", done_o, 0);

    // R5 start during busy ignored
    @(negedge clk_i);
    start_i = 1'b1;
    angle_i = 19'(-140000);
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    @(negedge clk_i);
    lat++;
    start_i = 1'b1;
    angle_i = 19'(40000);
    @(negedge clk_i);
    lat++;
    start_i = 1'b0;
    while (!done_o && lat < 50) begin
      @(negedge clk_i);
      lat++;
    end
    chk_int("R5 latency unchanged", lat, 7);
    chk_int("R5 sin unchanged", sin_o, s_a);
    chk_int("R5 cos unchanged", cos_o, c_a);
    @(negedge clk_i);
    chk_int("R5 no extra done", done_o, 0);

    // R6 start in the done cycle
    run_op(30000, s, c, lat);
    chk_int("R6 first done", done_o, 1);
    start_i = 1'b1;
    angle_i = 19'(-180000);
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 50) begin
      @(negedge clk_i);
      lat++;
    end
    chk_int("R6 back-to-back latency", lat, 7);
    chk_err("R6 sin", -180000, sin_o, 1'b1);
    chk_err("R6 cos", -180000, cos_o, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule